// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit

A multiply/divide coprocessor that sits beside the integer pipeline of a 32-bit core and owns a pair of 64-bit result registers, HI (upper word) and LO (lower word). The core issues an operation with a valid strobe, an opcode and two 32-bit operands. If the unit is occupied it raises `stall_o`, and the core holds the request until the stall drops.

Multiplication runs on a 33x17 signed array, which is a 32x16 array with one extra bit per operand for signedness. When the second operand fits in 16 bits, the product is complete after one pass. Otherwise a second pass handles the upper half of that operand. Besides the plain multiply into HI/LO, the unit supports accumulate into {HI,LO}, subtract from {HI,LO}, and a multiply whose low word goes straight back to the core on a result strobe.

Division is restoring and produces one quotient bit per clock. Before it starts, the unit checks how far the dividend is sign-extended (signed) or zero-extended (unsigned) and runs only 8, 16, 24 or 32 iterations.

Top module: `mdu_unit`

## Requirements
- R1: After reset, HI and LO read 0, and `busy_o`, `stall_o` and `res_valid_o` are low.
- R2: Multiply opcodes are 0 (signed) and 1 (unsigned). If the second operand fits in 16 bits (signed: bits 31..15 all equal; unsigned: bits 31..16 zero), the 64-bit product is written to {HI,LO} at the accepting edge, and `busy_o` stays low.
- R3: Any other second operand takes two passes. `busy_o` is high for exactly one cycle after acceptance, and {HI,LO} is written one edge later.
- R4: An issue while a second pass or a divide is active raises `stall_o` and is not accepted. Back-to-back one-pass multiplies never stall.
- R5: Opcodes 2/3 (signed/unsigned) add the 64-bit product to {HI,LO}. Opcodes 4/5 subtract it. Both wrap modulo 2^64.
- R6: Opcode 6 gives a one-cycle `res_valid_o` pulse with the low 32 bits of the signed product on `res_o`. HI and LO are unchanged. The pulse follows the same one- or two-pass timing.
- R7: Opcodes 7 (signed) and 8 (unsigned) divide. LO receives the quotient truncated toward zero. HI receives the remainder, which takes the sign of the dividend.
- R8: After a divide is accepted, `busy_o` stays high for N cycles. N is 8, 16, 24 or 32: the smallest width in which the dividend fits (signed: sign-extended; unsigned: zero-extended). The results appear after the last of those cycles.
- R9: Divide by zero completes with the same latency as R8, without any exception. The HI/LO contents are unspecified.
- R10: `hi_we_i` / `lo_we_i` load `wdata_i` into HI / LO at the clock edge. If a unit result writes the same register at the same edge, the unit result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Operation request |
| op_i | input | 4 | Opcode (see requirements) |
| opa_i | input | 32 | First operand / dividend |
| opb_i | input | 32 | Second operand / divisor |
| stall_o | output | 1 | Request present but not accepted |
| busy_o | output | 1 | Second pass or divide in progress |
| res_valid_o | output | 1 | Low-word multiply result strobe |
| res_o | output | 32 | Low-word multiply result |
| hi_we_i | input | 1 | Direct write enable for HI |
| lo_we_i | input | 1 | Direct write enable for LO |
| wdata_i | input | 32 | Direct write data |
| hi_o | output | 32 | HI contents |
| lo_o | output | 32 | LO contents |

## Verification
The assertions assume that a divide is never started while the unit is busy. They also assume that a stalled request is held unchanged until it is accepted. The issue task keeps a request asserted while `stall_o` is high and releases it only after the accepting edge, so both assumptions hold. Direct HI/LO writes are kept away from cycles in which the low-word multiply strobes, except in the one scenario that checks write priority. That scenario uses a plain multiply, not the low-word multiply.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam int XLEN = 32;
  localparam int HALF = XLEN / 2;
  localparam int WIDE = 2 * XLEN;
  localparam int STEP = 8;
  localparam int CNTW = $clog2(XLEN + 1);
  localparam int PW   = XLEN + HALF + 2;

  typedef enum logic [3:0] {
    OP_MULT  = 4'd0,
    OP_MULTU = 4'd1,
    OP_MADD  = 4'd2,
    OP_MADDU = 4'd3,
    OP_MSUB  = 4'd4,
    OP_MSUBU = 4'd5,
    OP_MUL   = 4'd6,
    OP_DIV   = 4'd7,
    OP_DIVU  = 4'd8
  } mdu_op_e;

  typedef enum logic [1:0] {K_SET, K_ADD, K_SUB, K_GPR} mul_kind_e;
endpackage

// File: rtl/mdu_mul_pass.sv
module mdu_mul_pass #(
  parameter int AW = 33,
  parameter int BW = 17
) (
  input  logic signed [AW-1:0]    a_i,
  input  logic signed [BW-1:0]    b_i,
  output logic signed [AW+BW-1:0] p_o
);
  assign p_o = a_i * b_i;
endmodule

// File: rtl/mdu_width_chk.sv
module mdu_width_chk import mdu_pkg::*; (
  input  logic               sgn_i,
  input  logic [XLEN-1:0]    a_i,
  input  logic [HALF:0]      b_hi_i,  // opb bits XLEN-1 .. HALF-1
  output logic               one_pass_o,
  output logic [CNTW-1:0]    iters_o
);
  assign one_pass_o = sgn_i ? (&b_hi_i | ~|b_hi_i) : ~|b_hi_i[HALF:1];

  // smallest byte-multiple width that holds the dividend
  always_comb begin
    logic [XLEN-1:0] m;
    iters_o = CNTW'(XLEN);
    for (int k = XLEN / STEP - 1; k >= 1; k--) begin
      m = {XLEN{1'b1}} << (k * STEP - 1);
      if (sgn_i ? (((a_i & m) == '0) || ((a_i & m) == m))
                : ((a_i & (m << 1)) == '0))
        iters_o = CNTW'(k * STEP);
    end
  end
endmodule

// File: rtl/mdu_div_core.sv
module mdu_div_core import mdu_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [CNTW-1:0] iters_i,
  input  logic [XLEN-1:0] dvd_mag_i,
  input  logic [XLEN-1:0] dvs_mag_i,
  output logic            busy_o,
  output logic            last_o,
  output logic [XLEN-1:0] quot_o,
  output logic [XLEN-1:0] rem_o
);
  logic [XLEN-1:0] rem_q, quo_q, dvs_q;
  logic [CNTW-1:0] cnt_q;
  logic [XLEN:0]   shifted, trial;
  logic            ge;

  assign shifted = {rem_q, quo_q[XLEN-1]};
  assign trial   = shifted - {1'b0, dvs_q};
  assign ge      = ~trial[XLEN];
  assign rem_o   = ge ? trial[XLEN-1:0] : shifted[XLEN-1:0];
  assign quot_o  = {quo_q[XLEN-2:0], ge};
  assign busy_o  = cnt_q != '0;
  assign last_o  = cnt_q == CNTW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      rem_q <= '0;
      quo_q <= dvd_mag_i << (CNTW'(XLEN) - iters_i);
      dvs_q <= dvs_mag_i;
      cnt_q <= iters_i;
    end else if (busy_o) begin
      rem_q <= rem_o;
      quo_q <= quot_o;
      cnt_q <= cnt_q - CNTW'(1);
    end
  end

  // R8
  div_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q > CNTW'(1)) |=> (cnt_q == $past(cnt_q) - CNTW'(1)));

  // R7
  div_rem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && dvs_q != '0) |-> (rem_q < dvs_q));
endmodule

// File: rtl/mdu_unit.sv
module mdu_unit import mdu_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_i,
  input  logic [3:0]      op_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic            stall_o,
  output logic            busy_o,
  output logic            res_valid_o,
  output logic [XLEN-1:0] res_o,
  input  logic            hi_we_i,
  input  logic            lo_we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] hi_o,
  output logic [XLEN-1:0] lo_o
);
  logic [XLEN-1:0] hi_q, lo_q, res_q;
  logic            res_valid_q, mul2_q, neg_q, rneg_q;
  logic [XLEN:0]   a33_q;
  logic [HALF:0]   bhi_q;
  logic [PW-1:0]   part_q;
  mul_kind_e       kind_q, kind, fire_kind;

  logic is_mul, is_div, sgn, accept, one_pass, div_busy, div_last, mul_fire;
  logic [CNTW-1:0] iters;
  logic signed [XLEN:0] pa;
  logic signed [HALF:0] pb;
  logic signed [PW-1:0] prod;
  logic [WIDE-1:0] prod_ext, part_ext, prod_fin, acc_n;
  logic [XLEN-1:0] dvd_mag, dvs_mag, quot_n, rem_n;

  always_comb begin
    is_mul = 1'b0;
    is_div = 1'b0;
    sgn    = 1'b0;
    kind   = K_SET;
    case (mdu_op_e'(op_i))
      OP_MULT:  begin is_mul = 1'b1; sgn = 1'b1; end
      OP_MULTU: is_mul = 1'b1;
      OP_MADD:  begin is_mul = 1'b1; sgn = 1'b1; kind = K_ADD; end
      OP_MADDU: begin is_mul = 1'b1; kind = K_ADD; end
      OP_MSUB:  begin is_mul = 1'b1; sgn = 1'b1; kind = K_SUB; end
      OP_MSUBU: begin is_mul = 1'b1; kind = K_SUB; end
      OP_MUL:   begin is_mul = 1'b1; sgn = 1'b1; kind = K_GPR; end
      OP_DIV:   begin is_div = 1'b1; sgn = 1'b1; end
      OP_DIVU:  is_div = 1'b1;
      default:  ;
    endcase
  end

  assign busy_o  = mul2_q | div_busy;
  assign stall_o = issue_i & busy_o;
  assign accept  = issue_i & ~busy_o;

  mdu_width_chk u_width (
    .sgn_i      (sgn),
    .a_i        (opa_i),
    .b_hi_i     (opb_i[XLEN-1:HALF-1]),
    .one_pass_o (one_pass),
    .iters_o    (iters)
  );

  // pass 1 uses the low half unsigned unless the whole operand fits
  assign pa = mul2_q ? a33_q : {sgn & opa_i[XLEN-1], opa_i};
  assign pb = mul2_q ? bhi_q : {sgn & one_pass & opb_i[HALF-1], opb_i[HALF-1:0]};

  mdu_mul_pass #(.AW(XLEN + 1), .BW(HALF + 1)) u_mul (
    .a_i (pa),
    .b_i (pb),
    .p_o (prod)
  );

  assign prod_ext  = {{(WIDE-PW){prod[PW-1]}}, prod};
  assign part_ext  = {{(WIDE-PW){part_q[PW-1]}}, part_q};
  assign prod_fin  = mul2_q ? (part_ext + (prod_ext << HALF)) : prod_ext;
  assign mul_fire  = (accept & is_mul & one_pass) | mul2_q;
  assign fire_kind = mul2_q ? kind_q : kind;

  always_comb begin
    case (fire_kind)
      K_ADD:   acc_n = {hi_q, lo_q} + prod_fin;
      K_SUB:   acc_n = {hi_q, lo_q} - prod_fin;
      default: acc_n = prod_fin;
    endcase
  end

  assign dvd_mag = (sgn & opa_i[XLEN-1]) ? -opa_i : opa_i;
  assign dvs_mag = (sgn & opb_i[XLEN-1]) ? -opb_i : opb_i;

  mdu_div_core u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept & is_div),
    .iters_i   (iters),
    .dvd_mag_i (dvd_mag),
    .dvs_mag_i (dvs_mag),
    .busy_o    (div_busy),
    .last_o    (div_last),
    .quot_o    (quot_n),
    .rem_o     (rem_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q        <= '0;
      lo_q        <= '0;
      res_q       <= '0;
      res_valid_q <= 1'b0;
      mul2_q      <= 1'b0;
      a33_q       <= '0;
      bhi_q       <= '0;
      part_q      <= '0;
      kind_q      <= K_SET;
      neg_q       <= 1'b0;
      rneg_q      <= 1'b0;
    end else begin
      res_valid_q <= 1'b0;
      if (hi_we_i) hi_q <= wdata_i;
      if (lo_we_i) lo_q <= wdata_i;
      if (mul2_q) mul2_q <= 1'b0;
      if (accept && is_mul && !one_pass) begin
        mul2_q <= 1'b1;
        a33_q  <= pa;
        bhi_q  <= {sgn & opb_i[XLEN-1], opb_i[XLEN-1:HALF]};
        part_q <= prod;
        kind_q <= kind;
      end
      // unit results override direct writes
      if (mul_fire) begin
        if (fire_kind == K_GPR) begin
          res_q       <= prod_fin[XLEN-1:0];
          res_valid_q <= 1'b1;
        end else begin
          {hi_q, lo_q} <= acc_n;
        end
      end
      if (accept && is_div) begin
        neg_q  <= sgn & (opa_i[XLEN-1] ^ opb_i[XLEN-1]);
        rneg_q <= sgn & opa_i[XLEN-1];
      end
      if (div_last) begin
        lo_q <= neg_q ? -quot_n : quot_n;
        hi_q <= rneg_q ? -rem_n : rem_n;
      end
    end
  end

  assign hi_o        = hi_q;
  assign lo_o        = lo_q;
  assign res_o       = res_q;
  assign res_valid_o = res_valid_q;

  // R3
  two_pass_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && is_mul && !one_pass) |=> busy_o ##1 !busy_o);

  // R6
  gpr_keeps_hilo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mul_fire && fire_kind == K_GPR && !hi_we_i && !lo_we_i)
      |=> (res_valid_o && $stable(hi_o) && $stable(lo_o)));

  // R4
  busy_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(issue_i));
endmodule

// File: tb/mdu_unit_test.sv
module mdu_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] opa_i = '0, opb_i = '0, wdata_i = '0;
  logic        hi_we_i = 1'b0, lo_we_i = 1'b0;
  logic        stall_o, busy_o, res_valid_o;
  logic [31:0] res_o, hi_o, lo_o;

  int total = 0;
  int bad = 0;
  logic [63:0] exp_hilo = '0;

  always #5 clk_i = ~clk_i;

  mdu_unit uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mref(input logic sgn, input logic [31:0] a, input logic [31:0] b);
    if (sgn) return 64'(longint'($signed(a)) * longint'($signed(b)));
    return 64'(a) * 64'(b);
  endfunction

  // starts and ends at a negedge
  task automatic do_issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                          output int stalls);
    issue_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
    stalls = 0;
    #1;
    while (stall_o) begin
      stalls++;
      @(negedge clk_i); #1;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    issue_i = 1'b0;
  endtask

  task automatic wr_reg(input logic is_hi, input logic [31:0] d);
    hi_we_i = is_hi; lo_we_i = ~is_hi; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    hi_we_i = 1'b0; lo_we_i = 1'b0;
    if (is_hi) exp_hilo[63:32] = d; else exp_hilo[31:0] = d;
    chk("R10 direct write", {hi_o, lo_o}, exp_hilo);
  endtask

  task automatic t_reset();
    chk("R1 reset hilo", {hi_o, lo_o}, 64'd0);
    chk("R1 reset flags", {61'd0, busy_o, stall_o, res_valid_o}, 64'd0);
  endtask

  task automatic t_mult_one(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    int s;
    do_issue(op, a, b, s);
    exp_hilo = mref(op == 4'd0, a, b);
    chk("R4 one-pass no stall", 64'(s), 64'd0);
    chk("R2 one-pass busy", 64'(busy_o), 64'd0);
    chk("R2 one-pass product", {hi_o, lo_o}, exp_hilo);
  endtask

  task automatic t_mult_two(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    int s;
    do_issue(op, a, b, s);
    exp_hilo = mref(op == 4'd0, a, b);
    chk("R3 two-pass busy", 64'(busy_o), 64'd1);
    @(negedge clk_i);
    chk("R3 two-pass product", {hi_o, lo_o}, exp_hilo);
    chk("R3 two-pass idle", 64'(busy_o), 64'd0);
  endtask

  task automatic t_b2b_two();
    int s;
    do_issue(4'd0, 32'h1234_5678, 32'h8765_4321, s);
    do_issue(4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, s);
    chk("R4 back-to-back two-pass stall", 64'(s), 64'd1);
    @(negedge clk_i);
    exp_hilo = mref(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R4 second two-pass product", {hi_o, lo_o}, exp_hilo);
  endtask

  task automatic t_b2b_one();
    int s1, s2;
    do_issue(4'd0, 32'd1000, 32'hFFFF_FFF9, s1);
    do_issue(4'd1, 32'hDEAD_BEEF, 32'h0000_FFFF, s2);
    exp_hilo = mref(1'b0, 32'hDEAD_BEEF, 32'h0000_FFFF);
    chk("R4 consecutive one-pass stalls", 64'(s1 + s2), 64'd0);
    chk("R4 consecutive one-pass product", {hi_o, lo_o}, exp_hilo);
  endtask

  task automatic t_acc(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic two);
    int s;
    logic [63:0] p;
    p = mref(op == 4'd2 || op == 4'd4, a, b);
    exp_hilo = (op == 4'd2 || op == 4'd3) ? exp_hilo + p : exp_hilo - p;
    do_issue(op, a, b, s);
    if (two) @(negedge clk_i);
    chk("R5 accumulate", {hi_o, lo_o}, exp_hilo);
  endtask

  task automatic t_gpr(input logic [31:0] a, input logic [31:0] b, input logic two);
    int s;
    logic [63:0] p;
    p = mref(1'b1, a, b);
    do_issue(4'd6, a, b, s);
    if (two) begin
      chk("R6 no strobe during second pass", 64'(res_valid_o), 64'd0);
      @(negedge clk_i);
    end
    chk("R6 strobe", 64'(res_valid_o), 64'd1);
    chk("R6 low word", 64'(res_o), {32'd0, p[31:0]});
    chk("R6 hilo untouched", {hi_o, lo_o}, exp_hilo);
    @(negedge clk_i);
    chk("R6 strobe one cycle", 64'(res_valid_o), 64'd0);
  endtask

  task automatic t_div(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input int iters);
    int s, n;
    logic [31:0] q, r;
    do_issue(op, a, b, s);
    n = 0;
    while (busy_o) begin
      n++;
      @(negedge clk_i);
    end
    if (b == 0) begin
      chk("R9 divide by zero latency", 64'(n), 64'(iters));
      chk("R9 divide by zero idle", 64'(busy_o), 64'd0);
      exp_hilo = {hi_o, lo_o};  // unspecified contents
    end else begin
      if (op == 4'd7) begin
        q = 32'($signed(a) / $signed(b));
        r = 32'($signed(a) % $signed(b));
      end else begin
        q = a / b;
        r = a % b;
      end
      exp_hilo = {r, q};
      chk("R8 divide latency", 64'(n), 64'(iters));
      chk("R7 quotient/remainder", {hi_o, lo_o}, exp_hilo);
    end
  endtask

  task automatic t_stall_div();
    int s;
    do_issue(4'd7, 32'h8000_0000, 32'd3, s);
    do_issue(4'd0, 32'd5, 32'd6, s);
    chk("R4 issue stalled through divide", 64'(s), 64'd32);
    exp_hilo = 64'd30;
    chk("R4 stalled multiply result", {hi_o, lo_o}, exp_hilo);
  endtask

  task automatic t_collide();
    int s;
    lo_we_i = 1'b1; wdata_i = 32'hDEAD_0001;
    do_issue(4'd0, 32'd3, 32'd4, s);
    lo_we_i = 1'b0;
    exp_hilo = 64'd12;
    chk("R10 unit result wins", {hi_o, lo_o}, exp_hilo);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();

    t_mult_one(4'd0, 32'd7, 32'hFFFF_FFFD);
    t_mult_one(4'd0, 32'h8000_0000, 32'hFFFF_8000);
    t_mult_one(4'd1, 32'hFFFF_FFFF, 32'h0000_FFFF);
    t_mult_two(4'd0, 32'h1234_5678, 32'h8765_4321);
    t_mult_two(4'd0, 32'hFFFF_FFFF, 32'h0000_8000);
    t_mult_two(4'd0, 32'd9, 32'h0000_FFFF);
    t_mult_two(4'd1, 32'hFFFF_FFFF, 32'h0001_0000);
    t_b2b_two();
    t_b2b_one();

    wr_reg(1'b1, 32'h0000_0001);
    wr_reg(1'b0, 32'hFFFF_FFF0);
    t_acc(4'd2, 32'd100, 32'd200, 1'b0);
    t_acc(4'd2, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b1);
    t_acc(4'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    t_acc(4'd4, 32'hFFFF_FF00, 32'd50, 1'b0);
    t_acc(4'd5, 32'h8000_0000, 32'h8000_0000, 1'b1);

    t_gpr(32'h0001_0003, 32'hFFFF_FFFE, 1'b0);
    t_gpr(32'h1234_5678, 32'h0012_3456, 1'b1);

    t_div(4'd7, 32'hFFFF_FF9C, 32'd7, 8);
    t_div(4'd7, 32'hFFFF_FF80, 32'd1, 8);
    t_div(4'd7, 32'd128, 32'd5, 16);
    t_div(4'd7, 32'd1000, 32'hFFFF_FFF9, 16);
    t_div(4'd7, 32'h0040_0000, 32'd3, 24);
    t_div(4'd7, 32'h8000_0000, 32'd3, 32);
    t_div(4'd8, 32'd255, 32'd3, 8);
    t_div(4'd8, 32'd256, 32'd3, 16);
    t_div(4'd8, 32'hFFFF_FFFF, 32'h10, 32);
    t_div(4'd7, 32'd50, 32'd0, 8);
    t_div(4'd8, 32'h0100_0000, 32'd0, 32);

    t_stall_div();
    t_collide();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule